// File: doc/BRIEF.md
# One-Hot Row Scan Driver

This block is the digital core of a row driver for a scanned display with a parameterised number of rows (40 by default). A single active token moves through the row positions, one position per rising clock edge. At most one row is active at any time. Each row output is an enable plus a drive value. An active row is driven to the level given by the polarity pin, and every inactive row floats. A global disable pin floats all rows at once.

A token pulse enters on one of two token terminals and starts a scan. Each terminal is modelled as an input port, an output port and an output-enable port. The direction pin decides which terminal receives the token and which one sends it on. The token leaves on the other terminal exactly one row count of clocks later, so a second device wired to that terminal begins its scan as soon as this one ends. The outgoing token changes on the falling clock edge, half a period after the rising edge that moved the token.

Two pins select the scan order, giving four orders. The first is a linear walk in either direction. The second is a split order that scans one half of the rows and then the other half. Both pins may change while a scan is running. The scan then continues from the same step count, placed on the new order.

Top module: `row_scan_drv`

## Requirements
- R1: When the selected token input is high at a rising clock edge, any token already in flight is discarded. The token is placed on step 0 of the selected order, and that row is active after the edge.
- R2: Without a new token input, the token advances one step per rising edge. The edge after step N-1 (step 39 by default) leaves no row active.
- R3: With dir=1, terminal A is the token input and terminal B is the output (`tok_b_oe`=1, `tok_a_oe`=0). With dir=0 the roles are swapped. A token pulse on the terminal that is currently the output starts nothing.
- R4: With scan_split=0, rows are visited 1,2,...,40 when dir=1 and 40,39,...,1 when dir=0. Row k maps to bit k-1 of `row_en` and `row_val`.
- R5: With scan_split=1, rows are visited 21..40 then 1..20 when dir=1, and 20 down to 1 then 40 down to 21 when dir=0.
- R6: The output terminal goes high for one clock. It rises on the falling edge that follows the N-th rising edge after the edge that loaded the token.
- R7: For an active row, `row_val` equals pol. For every inactive row, `row_en`=0 and `row_val`=0.
- R8: When out_dis=1, every `row_en` and `row_val` bit is 0. Token movement is not affected.
- R9: At most one bit of `row_en` is set at any time.
- R10: An asynchronous low on rst_n at once clears the token, the scan state and the token outputs, so no row is active.
- R11: A change of dir or scan_split takes effect at the next rising edge. The token keeps its step count and is placed on the new order, and no second row becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; token moves on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir | input | 1 | 1: A in / B out, forward order; 0: B in / A out, reverse order |
| scan_split | input | 1 | 1: split-half order, 0: linear order |
| pol | input | 1 | Drive level for the active row |
| out_dis | input | 1 | 1: float all rows |
| tok_a_in | input | 1 | Token terminal A, input side |
| tok_b_in | input | 1 | Token terminal B, input side |
| tok_a_out | output | 1 | Token terminal A, output side |
| tok_a_oe | output | 1 | Terminal A drives when 1 |
| tok_b_out | output | 1 | Token terminal B, output side |
| tok_b_oe | output | 1 | Terminal B drives when 1 |
| row_en | output | N_ROWS | Per-row drive enable (0 = high impedance) |
| row_val | output | N_ROWS | Per-row drive level when enabled |

## Verification
A full scan is run in each of the four orders, with the expected row listed step by step. This separates the linear order from the split order and the forward direction from the reverse, and the check after the last step confirms that the carry-out is exactly N clocks late. Other scans test the token input: one pulse arrives on the terminal that is currently the output, another arrives mid-scan, and a reset is asserted mid-scan. A further scan changes the mode pins part way through, which tests the remapping. Still other scans toggle pol and out_dis during a scan, to show that they shape the drive without moving the token.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;

  typedef struct packed {
    logic rev;    // walk from the high end
    logic split;  // two-half ordering
  } scan_mode_t;

  // Map a step count of the scan to a zero-based row index.
  function automatic int unsigned row_of_step(int unsigned s, int unsigned n,
                                              scan_mode_t m);
    int unsigned h;
    h = n / 2;
    if (!m.split) return m.rev ? (n - 1 - s) : s;
    if (!m.rev)   return (s < h) ? (s + h) : (s - h);
    return (s < h) ? (h - 1 - s) : (n + h - 1 - s);
  endfunction

endpackage

// File: rtl/row_scan_seq.sv
module row_scan_seq
  import row_scan_pkg::*;
#(
  parameter int N_ROWS = 40,
  parameter int STEP_W = $clog2(N_ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  scan_mode_t        mode_in,
  output logic              active,
  output logic [STEP_W-1:0] step,
  output scan_mode_t        mode_q,
  output logic              carry,
  output logic              at_last
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(N_ROWS - 1);

  assign at_last = (step == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      step   <= '0;
      carry  <= 1'b0;
      mode_q <= '0;
    end else begin
      mode_q <= mode_in;
      carry  <= active & ~load & at_last;
      if (load) begin
        active <= 1'b1;
        step   <= '0;
      end else if (active) begin
        if (at_last) active <= 1'b0;
        else         step   <= step + 1'b1;
      end
    end
  end
endmodule

// File: rtl/row_scan_port.sv
module row_scan_port (
  input  logic clk,
  input  logic rst_n,
  input  logic dir,
  input  logic a_in,
  input  logic b_in,
  input  logic carry,
  output logic load,
  output logic tok_q,
  output logic a_out,
  output logic a_oe,
  output logic b_out,
  output logic b_oe
);
  assign load = dir ? a_in : b_in;

  // Outgoing token lags the moving edge by the clock high time.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) tok_q <= 1'b0;
    else        tok_q <= carry;
  end

  assign a_oe  = ~dir;
  assign b_oe  = dir;
  assign a_out = ~dir & tok_q;
  assign b_out = dir & tok_q;
endmodule

// File: rtl/row_scan_decode.sv
module row_scan_decode #(
  parameter int N_ROWS = 40,
  parameter int STEP_W = $clog2(N_ROWS)
) (
  input  logic              active,
  input  logic [STEP_W-1:0] row_idx,
  input  logic              pol,
  input  logic              out_dis,
  output logic [N_ROWS-1:0] en,
  output logic [N_ROWS-1:0] val
);
  for (genvar i = 0; i < N_ROWS; i++) begin : g_row
    assign en[i]  = active & ~out_dis & (row_idx == STEP_W'(i));
    assign val[i] = en[i] & pol;
  end
endmodule

// File: rtl/row_scan_drv.sv
module row_scan_drv
  import row_scan_pkg::*;
#(
  parameter int N_ROWS = 40,
  parameter int STEP_W = $clog2(N_ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir,
  input  logic              scan_split,
  input  logic              pol,
  input  logic              out_dis,
  input  logic              tok_a_in,
  input  logic              tok_b_in,
  output logic              tok_a_out,
  output logic              tok_a_oe,
  output logic              tok_b_out,
  output logic              tok_b_oe,
  output logic [N_ROWS-1:0] row_en,
  output logic [N_ROWS-1:0] row_val
);
  scan_mode_t        mode_in;
  scan_mode_t        seq_mode;
  logic              seq_load;
  logic              seq_active;
  logic [STEP_W-1:0] seq_step;
  logic              seq_carry;
  logic              seq_last;
  logic              tok_q;
  logic [STEP_W-1:0] row_idx;

  assign mode_in.rev   = ~dir;
  assign mode_in.split = scan_split;

  row_scan_port u_port (
    .clk(clk), .rst_n(rst_n), .dir(dir), .a_in(tok_a_in), .b_in(tok_b_in),
    .carry(seq_carry), .load(seq_load), .tok_q(tok_q),
    .a_out(tok_a_out), .a_oe(tok_a_oe), .b_out(tok_b_out), .b_oe(tok_b_oe)
  );

  row_scan_seq #(.N_ROWS(N_ROWS), .STEP_W(STEP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(seq_load), .mode_in(mode_in),
    .active(seq_active), .step(seq_step), .mode_q(seq_mode),
    .carry(seq_carry), .at_last(seq_last)
  );

  assign row_idx = STEP_W'(row_of_step(32'(seq_step), unsigned'(N_ROWS), seq_mode));

  row_scan_decode #(.N_ROWS(N_ROWS), .STEP_W(STEP_W)) u_dec (
    .active(seq_active), .row_idx(row_idx), .pol(pol), .out_dis(out_dis),
    .en(row_en), .val(row_val)
  );
endmodule

// File: rtl/row_scan_chk.sv
module row_scan_chk #(
  parameter int N_ROWS = 40,
  parameter int STEP_W = $clog2(N_ROWS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dir,
  input logic              pol,
  input logic              out_dis,
  input logic              load,
  input logic              active,
  input logic [STEP_W-1:0] step,
  input logic              carry,
  input logic              tok_a_out,
  input logic              tok_b_out,
  input logic [N_ROWS-1:0] row_en,
  input logic [N_ROWS-1:0] row_val
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(N_ROWS - 1);

  AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (active && step == '0)); // R1
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !load && step != LAST) |=> (active && step == $past(step) + 1'b1)); // R2
  AST_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !load && step == LAST) |=> (!active && carry)); // R2
  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (row_en == '0)); // R2
  AST_TOKEN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    dir |-> (tok_b_out == carry && !tok_a_out)); // R6
  AST_POL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (|row_en) |-> ((|row_val) == pol)); // R7
  AST_DIS_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_dis |-> (row_en == '0 && row_val == '0)); // R8
  AST_ONE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_en)); // R9
endmodule

bind row_scan_drv row_scan_chk #(.N_ROWS(N_ROWS), .STEP_W(STEP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir(dir), .pol(pol), .out_dis(out_dis),
  .load(seq_load), .active(seq_active), .step(seq_step), .carry(seq_carry),
  .tok_a_out(tok_a_out), .tok_b_out(tok_b_out),
  .row_en(row_en), .row_val(row_val)
);

// File: tb/row_scan_drv_bench.sv
module row_scan_drv_bench;
  localparam int N = 40;
  localparam int H = N / 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, dir, scan_split, pol, out_dis, tok_a_in, tok_b_in;
  logic tok_a_out, tok_a_oe, tok_b_out, tok_b_oe;
  logic [N-1:0] row_en, row_val;
  int total = 0;
  int bad = 0;
  bit done = 0;

  row_scan_drv #(.N_ROWS(N)) u_row_scan_drv (
    .clk(clk), .rst_n(rst_n), .dir(dir), .scan_split(scan_split), .pol(pol),
    .out_dis(out_dis), .tok_a_in(tok_a_in), .tok_b_in(tok_b_in),
    .tok_a_out(tok_a_out), .tok_a_oe(tok_a_oe), .tok_b_out(tok_b_out),
    .tok_b_oe(tok_b_oe), .row_en(row_en), .row_val(row_val)
  );

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Expected 1-based row at step k for the given pins.
  function automatic int exp_row(bit d, bit sh, int k);
    int seq[N];
    int p = 0;
    if (!sh) begin
      for (int r = 1; r <= N; r++) seq[p++] = d ? r : N + 1 - r;
    end else if (d) begin
      for (int r = H + 1; r <= N; r++) seq[p++] = r;
      for (int r = 1; r <= H; r++) seq[p++] = r;
    end else begin
      for (int r = H; r >= 1; r--) seq[p++] = r;
      for (int r = N; r > H; r--) seq[p++] = r;
    end
    return seq[k];
  endfunction

  function automatic logic [N-1:0] onehot_of(int row);
    logic [N-1:0] v = '0;
    if (row > 0) v[row-1] = 1'b1;
    return v;
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk_rows(int row, string tag);
    logic [N-1:0] e;
    e = out_dis ? '0 : onehot_of(row);
    check(row_en == e, {tag, " row_en"}, 64'(row_en), 64'(e));
    check(row_val == (pol ? e : '0), {tag, " row_val"}, 64'(row_val), 64'(pol ? e : '0));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    check(row_en == '0 && tok_a_out == 0 && tok_b_out == 0, "R10 reset clears",
          64'(row_en), 64'd0);
    tick();
    rst_n = 1'b1;
  endtask

  task automatic start_token(bit d, bit sh);
    dir = d; scan_split = sh;
    if (d) tok_a_in = 1'b1; else tok_b_in = 1'b1;
    tick();
    tok_a_in = 1'b0; tok_b_in = 1'b0;
  endtask

  task automatic t_full_scan(bit d, bit sh, string tag);
    logic o;
    do_reset();
    pol = 1'b1; out_dis = 1'b0;
    start_token(d, sh);
    chk_rows(exp_row(d, sh, 0), {tag, " R1 first row"});
    for (int k = 1; k < N; k++) begin
      tick();
      chk_rows(exp_row(d, sh, k), tag);
    end
    tick();
    chk_rows(0, "R2 none after last step");
    o = d ? tok_b_out : tok_a_out;
    check(o == 1'b0, "R6 out not yet high", 64'(o), 64'd0);
    tick();
    o = d ? tok_b_out : tok_a_out;
    check(o == 1'b1, "R6 token out after N clocks", 64'(o), 64'd1);
    check((d ? tok_a_out : tok_b_out) == 1'b0, "R3 input terminal quiet",
          64'(d ? tok_a_out : tok_b_out), 64'd0);
    check(tok_b_oe == d && tok_a_oe == !d, "R3 terminal enables",
          64'({tok_a_oe, tok_b_oe}), 64'({!d, d}));
    tick();
    o = d ? tok_b_out : tok_a_out;
    check(o == 1'b0, "R6 token out one clock", 64'(o), 64'd0);
  endtask

  task automatic t_wrong_terminal();
    do_reset();
    dir = 1'b1; scan_split = 1'b0;
    tok_b_in = 1'b1;
    tick();
    tok_b_in = 1'b0;
    chk_rows(0, "R3 output-side pulse ignored");
    tick();
    chk_rows(0, "R3 still idle");
    dir = 1'b0;
    tok_a_in = 1'b1;
    tick();
    tok_a_in = 1'b0;
    chk_rows(0, "R3 output-side pulse ignored dir0");
  endtask

  task automatic t_pol_dis();
    do_reset();
    pol = 1'b0; out_dis = 1'b0;
    start_token(1'b1, 1'b0);
    chk_rows(1, "R7 low drive");
    tick(); chk_rows(2, "R7 low drive");
    pol = 1'b1;
    #1 chk_rows(2, "R7 high drive");
    out_dis = 1'b1;
    for (int k = 2; k < 5; k++) begin
      tick();
      chk_rows(0, "R8 all float");
    end
    out_dis = 1'b0;
    #1 chk_rows(5, "R8 token kept moving");
    tick(); chk_rows(6, "R8 resume");
  endtask

  task automatic t_mode_change();
    do_reset();
    pol = 1'b1; out_dis = 1'b0;
    start_token(1'b1, 1'b0);
    for (int k = 1; k <= 5; k++) tick();
    chk_rows(6, "R11 before change");
    dir = 1'b0;
    #1 chk_rows(6, "R11 no change before edge");
    tick();
    chk_rows(exp_row(1'b0, 1'b0, 6), "R11 remap reverse");
    scan_split = 1'b1;
    tick();
    chk_rows(exp_row(1'b0, 1'b1, 7), "R11 remap split");
    check($countones(row_en) == 1, "R9 single row", 64'($countones(row_en)), 64'd1);
  endtask

  task automatic t_retrigger();
    do_reset();
    pol = 1'b1; out_dis = 1'b0;
    start_token(1'b1, 1'b1);
    for (int k = 1; k <= 10; k++) tick();
    chk_rows(exp_row(1'b1, 1'b1, 10), "R5 split mid");
    start_token(1'b1, 1'b1);
    chk_rows(exp_row(1'b1, 1'b1, 0), "R1 retrigger restarts");
    tick();
    chk_rows(exp_row(1'b1, 1'b1, 1), "R1 retrigger advance");
  endtask

  task automatic t_reset_mid();
    do_reset();
    pol = 1'b1; out_dis = 1'b0;
    start_token(1'b0, 1'b0);
    tick(); tick();
    chk_rows(exp_row(1'b0, 1'b0, 2), "R10 running");
    rst_n = 1'b0;
    #1 chk_rows(0, "R10 async clear");
    tick();
    rst_n = 1'b1;
    tick();
    chk_rows(0, "R10 stays idle");
  endtask

  initial begin
    rst_n = 1'b0; dir = 1'b1; scan_split = 1'b0; pol = 1'b1; out_dis = 1'b0;
    tok_a_in = 1'b0; tok_b_in = 1'b0;
    #3;
    check(row_en == '0 && row_val == '0, "R10 reset state rows", 64'(row_en), 64'd0);
    check(tok_a_out == 0 && tok_b_out == 0, "R10 reset state tokens",
          64'({tok_a_out, tok_b_out}), 64'd0);
    tick();
    t_full_scan(1'b1, 1'b0, "R4 linear fwd");
    t_full_scan(1'b0, 1'b0, "R4 linear rev");
    t_full_scan(1'b1, 1'b1, "R5 split fwd");
    t_full_scan(1'b0, 1'b1, "R5 split rev");
    t_wrong_terminal();
    t_pol_dis();
    t_mode_change();
    t_retrigger();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule